// File: doc/BRIEF.md
# Shift-Register LIFO Stack

This block is a last-in first-out store built as a linear chain of storage cells. There is no read or write pointer. The most recent word always sits in the first cell of the chain, and every push or pop moves the stored words one position along the chain.

A push loads the incoming word into the first cell, and every older word moves one cell deeper. A pop delivers the first cell and moves every remaining word one cell toward the top. A peek delivers the first cell and leaves the contents alone.

A separate occupancy counter drives the empty and full flags. Misuse is reported on single-cycle pulse outputs:
- A push into a full stack is dropped and raises the overflow pulse.
- A pop from an empty stack returns zero and raises the underflow pulse.

Read results from a pop or a peek are registered. They appear on the read port one clock after the request, together with a valid pulse. A read returns the top word as it stood before that cycle's update.

Top module: `stk_shift_stack`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the count is 0, empty is 1, full is 0, and the read-valid, overflow and underflow pulses are 0.
- R2: An accepted push (push without pop, stack not full) writes the input word into the top cell, moves every older word one cell deeper, and increases the count by one on the next clock.
- R3: A pop without push on a non-empty stack presents the top word on the read data one clock later with read-valid high, decreases the count by one, and successive pops return words in reverse order of their pushes.
- R4: A peek without pop presents the top word one clock later with read-valid high and changes neither the count nor any stored word.
- R5: Empty is 1 exactly when the count is 0, and full is 1 exactly when the count equals DEPTH-1, the capacity of the stack.
- R6: A push without pop while full leaves the contents and count unchanged and raises overflow for exactly one cycle.
- R7: A pop without push while empty returns zero on the read data with read-valid high, raises underflow for one cycle, and leaves the count at 0.
- R8: A push with a pop on a non-empty stack returns the old top word, puts the new word in the top cell, leaves deeper words in place, and keeps the count unchanged.
- R9: A push with a pop on an empty stack reports underflow with zero read data, and the push is still accepted, so the count becomes 1.
- R10: Cells left vacated at the deep end when words move toward the top hold zero, so a peek on a stack emptied by pops returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push request for this cycle |
| pop_i | input | 1 | Destructive read request for this cycle |
| peek_i | input | 1 | Non-destructive read request for this cycle |
| wdata_i | input | DATA_W | Word to push |
| rdata_o | output | DATA_W | Result of the last pop or peek |
| rvalid_o | output | 1 | One-cycle pulse marking a new read result |
| count_o | output | $clog2(DEPTH) | Number of stored words |
| empty_o | output | 1 | Stack holds no words |
| full_o | output | 1 | Stack holds DEPTH-1 words |
| overflow_o | output | 1 | One-cycle pulse after a dropped push |
| underflow_o | output | 1 | One-cycle pulse after a pop on an empty stack |

## Verification
The properties assume that the request inputs always carry known 0 or 1 values at each rising edge. They also assume that reset is held across at least one edge before operation starts. The bench meets these assumptions by driving every input only at falling edges and from defined constants. It holds reset for several cycles and always returns the requests to zero between scenarios. Each scenario sets up its own occupancy, including completely full and completely empty, before it exercises the overflow, underflow and simultaneous push-and-pop corners.

// File: rtl/stk_pkg.sv
package stk_pkg;
   typedef enum logic [1:0] {
      SH_HOLD = 2'd0,
      SH_DOWN = 2'd1,
      SH_UP   = 2'd2,
      SH_SWAP = 2'd3
   } shift_op_e;
endpackage

// File: rtl/stk_cell.sv
module stk_cell
   import stk_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter bit IS_TOP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  shift_op_e         op_i,
   input  logic [DATA_W-1:0] near_i,
   input  logic [DATA_W-1:0] far_i,
   output logic [DATA_W-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o <= '0;
      end else begin
         unique case (op_i)
            SH_DOWN: q_o <= near_i;
            SH_UP:   q_o <= far_i;
            SH_SWAP: if (IS_TOP) q_o <= near_i;
            default: q_o <= q_o;
         endcase
      end
   end
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
   import stk_pkg::*;
#(
   parameter int DEPTH = 8,
   localparam int CAP   = DEPTH - 1,
   localparam int CNT_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic             pop_i,
   input  logic             peek_i,
   output shift_op_e        op_o,
   output logic             load_o,
   output logic             zero_o,
   output logic [CNT_W-1:0] count_o,
   output logic             empty_o,
   output logic             full_o,
   output logic             rvalid_o,
   output logic             overflow_o,
   output logic             underflow_o
);
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             ovf_d, udf_d;

   assign empty_o = (cnt_q == '0);
   assign full_o  = (cnt_q == CNT_W'(CAP));
   assign count_o = cnt_q;

   always_comb begin
      op_o   = SH_HOLD;
      load_o = 1'b0;
      zero_o = 1'b0;
      ovf_d  = 1'b0;
      udf_d  = 1'b0;
      cnt_d  = cnt_q;
      if (push_i && pop_i && !empty_o) begin
         op_o   = SH_SWAP;
         load_o = 1'b1;
      end else begin
         if (pop_i) begin
            if (empty_o) begin
               udf_d  = 1'b1;
               zero_o = 1'b1;
            end else begin
               op_o   = SH_UP;
               load_o = 1'b1;
               cnt_d  = cnt_q - CNT_W'(1);
            end
         end
         if (push_i) begin
            if (full_o) begin
               ovf_d = 1'b1;
            end else begin
               op_o  = SH_DOWN;
               cnt_d = cnt_q + CNT_W'(1);
            end
         end
         if (peek_i && !pop_i) load_o = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q       <= '0;
         rvalid_o    <= 1'b0;
         overflow_o  <= 1'b0;
         underflow_o <= 1'b0;
      end else begin
         cnt_q       <= cnt_d;
         rvalid_o    <= load_o | zero_o;
         overflow_o  <= ovf_d;
         underflow_o <= udf_d;
      end
   end
endmodule

// File: rtl/stk_shift_stack.sv
module stk_shift_stack
   import stk_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 8,
   localparam int CAP   = DEPTH - 1,
   localparam int CNT_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic              pop_i,
   input  logic              peek_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              rvalid_o,
   output logic [CNT_W-1:0]  count_o,
   output logic              empty_o,
   output logic              full_o,
   output logic              overflow_o,
   output logic              underflow_o
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("stk_shift_stack: DEPTH must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("stk_shift_stack: DATA_W must be positive");
   end

   shift_op_e         op;
   logic              load, zero;
   logic [DATA_W-1:0] cell_q [CAP];

   stk_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_i     (push_i),
      .pop_i      (pop_i),
      .peek_i     (peek_i),
      .op_o       (op),
      .load_o     (load),
      .zero_o     (zero),
      .count_o    (count_o),
      .empty_o    (empty_o),
      .full_o     (full_o),
      .rvalid_o   (rvalid_o),
      .overflow_o (overflow_o),
      .underflow_o(underflow_o)
   );

   for (genvar i = 0; i < CAP; i++) begin : g_chain
      logic [DATA_W-1:0] near, far;
      if (i == 0) begin : g_near_in
         assign near = wdata_i;
      end else begin : g_near_prev
         assign near = cell_q[i-1];
      end
      if (i == CAP - 1) begin : g_far_zero
         assign far = '0;
      end else begin : g_far_next
         assign far = cell_q[i+1];
      end
      stk_cell #(.DATA_W(DATA_W), .IS_TOP(i == 0)) u_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .op_i  (op),
         .near_i(near),
         .far_i (far),
         .q_o   (cell_q[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_o <= '0;
      end else if (zero) begin
         rdata_o <= '0;
      end else if (load) begin
         rdata_o <= cell_q[0];
      end
   end
endmodule

// File: rtl/stk_shift_stack_chk.sv
module stk_shift_stack_chk #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 8,
   localparam int CAP   = DEPTH - 1,
   localparam int CNT_W = $clog2(DEPTH)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              push_i,
   input logic              pop_i,
   input logic              peek_i,
   input logic [DATA_W-1:0] rdata_o,
   input logic              rvalid_o,
   input logic [CNT_W-1:0]  count_o,
   input logic              empty_o,
   input logic              full_o,
   input logic              overflow_o,
   input logic              underflow_o
);
   a_r2_push_count: assert property (@(posedge clk) disable iff (!rst_n)
      push_i && !pop_i && !full_o |=> count_o == $past(count_o) + CNT_W'(1));

   a_r3_pop_count: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i && !push_i && !empty_o |=> rvalid_o && count_o == $past(count_o) - CNT_W'(1));

   a_r4_peek_hold: assert property (@(posedge clk) disable iff (!rst_n)
      peek_i && !push_i && !pop_i |=> rvalid_o && $stable(count_o));

   a_r5_range: assert property (@(posedge clk) disable iff (!rst_n)
      count_o <= CNT_W'(CAP));

   a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      full_o |-> !empty_o);

   a_r6_no_overflow_growth: assert property (@(posedge clk) disable iff (!rst_n)
      push_i && !pop_i && full_o |=> overflow_o && full_o && $stable(count_o));

   a_r7_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i && !push_i && empty_o |=> underflow_o && rvalid_o && rdata_o == '0 && empty_o);

   a_r8_swap: assert property (@(posedge clk) disable iff (!rst_n)
      push_i && pop_i && !empty_o |=> rvalid_o && $stable(count_o) && !overflow_o && !underflow_o);

   a_r9_swap_empty: assert property (@(posedge clk) disable iff (!rst_n)
      push_i && pop_i && empty_o |=> underflow_o && rdata_o == '0 && count_o == CNT_W'(1));

   a_r6_pulses_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
      !(overflow_o && underflow_o));
endmodule

bind stk_shift_stack stk_shift_stack_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .push_i     (push_i),
   .pop_i      (pop_i),
   .peek_i     (peek_i),
   .rdata_o    (rdata_o),
   .rvalid_o   (rvalid_o),
   .count_o    (count_o),
   .empty_o    (empty_o),
   .full_o     (full_o),
   .overflow_o (overflow_o),
   .underflow_o(underflow_o)
);

// File: tb/stk_shift_stack_tb.sv
module stk_shift_stack_tb;
   localparam int DW    = 16;
   localparam int DEPTH = 8;
   localparam int CAP   = DEPTH - 1;
   localparam int CW    = $clog2(DEPTH);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          push_i = 1'b0, pop_i = 1'b0, peek_i = 1'b0;
   logic [DW-1:0] wdata_i = '0;
   logic [DW-1:0] rdata_o;
   logic          rvalid_o, empty_o, full_o, overflow_o, underflow_o;
   logic [CW-1:0] count_o;

   int n_checks = 0;
   int n_err    = 0;

   always #10 clk = ~clk;

   stk_shift_stack #(.DATA_W(DW), .DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .peek_i(peek_i),
      .wdata_i(wdata_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o), .count_o(count_o),
      .empty_o(empty_o), .full_o(full_o), .overflow_o(overflow_o), .underflow_o(underflow_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // drive at a falling edge, return at the next falling edge
   task automatic step(input logic ps, input logic pp, input logic pk, input int d);
      push_i  = ps;
      pop_i   = pp;
      peek_i  = pk;
      wdata_i = DW'(d);
      @(negedge clk);
      push_i = 1'b0;
      pop_i  = 1'b0;
      peek_i = 1'b0;
   endtask

   task automatic drain();
      while (!empty_o) step(0, 1, 0, 0);
      step(0, 0, 0, 0);
   endtask

   task automatic t_reset();
      chk("R1", "count in reset", int'(count_o), 0);
      chk("R1", "empty in reset", int'(empty_o), 1);
      chk("R1", "full in reset", int'(full_o), 0);
      chk("R1", "pulses in reset", int'({rvalid_o, overflow_o, underflow_o}), 0);
      rst_n = 1'b1;
      step(0, 0, 0, 0);
      chk("R1", "count after reset", int'(count_o), 0);
      chk("R5", "empty after reset", int'(empty_o), 1);
   endtask

   task automatic t_fill_drain();
      for (int i = 0; i < CAP; i++) begin
         step(1, 0, 0, 'h100 + i);
         chk("R2", "count while filling", int'(count_o), i + 1);
         chk("R5", "full while filling", int'(full_o), (i + 1 == CAP) ? 1 : 0);
         chk("R5", "empty while filling", int'(empty_o), 0);
      end
      step(1, 0, 0, 'hDEAD);
      chk("R6", "overflow pulse", int'(overflow_o), 1);
      chk("R6", "count after dropped push", int'(count_o), CAP);
      step(0, 0, 0, 0);
      chk("R6", "overflow single cycle", int'(overflow_o), 0);
      for (int i = CAP - 1; i >= 0; i--) begin
         step(0, 1, 0, 0);
         chk("R3", "pop data LIFO", int'(rdata_o), 'h100 + i);
         chk("R3", "pop valid", int'(rvalid_o), 1);
         chk("R3", "count while draining", int'(count_o), i);
      end
      chk("R5", "empty after drain", int'(empty_o), 1);
      step(0, 0, 0, 0);
      chk("R3", "valid drops", int'(rvalid_o), 0);
   endtask

   task automatic t_peek();
      step(1, 0, 0, 'h0A1);
      step(1, 0, 0, 'h0A2);
      step(0, 0, 1, 0);
      chk("R4", "peek data", int'(rdata_o), 'h0A2);
      chk("R4", "peek valid", int'(rvalid_o), 1);
      chk("R4", "peek count", int'(count_o), 2);
      step(0, 0, 1, 0);
      chk("R4", "second peek data", int'(rdata_o), 'h0A2);
      step(0, 1, 0, 0);
      chk("R4", "pop after peek", int'(rdata_o), 'h0A2);
      step(0, 1, 0, 0);
      chk("R2", "older word shifted", int'(rdata_o), 'h0A1);
      step(0, 0, 0, 0);
   endtask

   task automatic t_underflow();
      step(0, 1, 0, 0);
      chk("R7", "underflow pulse", int'(underflow_o), 1);
      chk("R7", "underflow data", int'(rdata_o), 0);
      chk("R7", "underflow valid", int'(rvalid_o), 1);
      chk("R7", "underflow count", int'(count_o), 0);
      step(0, 0, 0, 0);
      chk("R7", "underflow single cycle", int'(underflow_o), 0);
   endtask

   task automatic t_swap();
      step(1, 0, 0, 'h0B1);
      step(1, 0, 0, 'h0B2);
      step(1, 1, 0, 'h0B3);
      chk("R8", "swap returns old top", int'(rdata_o), 'h0B2);
      chk("R8", "swap count", int'(count_o), 2);
      chk("R8", "swap no flags", int'({overflow_o, underflow_o}), 0);
      step(0, 1, 0, 0);
      chk("R8", "new top", int'(rdata_o), 'h0B3);
      step(0, 1, 0, 0);
      chk("R8", "deeper word kept", int'(rdata_o), 'h0B1);
      step(0, 0, 0, 0);
      for (int i = 0; i < CAP; i++) step(1, 0, 0, 'h200 + i);
      step(1, 1, 0, 'h2FF);
      chk("R8", "swap when full data", int'(rdata_o), 'h200 + CAP - 1);
      chk("R8", "swap when full no overflow", int'(overflow_o), 0);
      chk("R8", "swap when full count", int'(count_o), CAP);
      step(0, 1, 0, 0);
      chk("R8", "full swap new top", int'(rdata_o), 'h2FF);
      drain();
   endtask

   task automatic t_swap_empty();
      step(1, 1, 0, 'h0C7);
      chk("R9", "underflow on empty swap", int'(underflow_o), 1);
      chk("R9", "zero data", int'(rdata_o), 0);
      chk("R9", "push accepted", int'(count_o), 1);
      step(0, 1, 0, 0);
      chk("R9", "pushed word", int'(rdata_o), 'h0C7);
      step(0, 0, 0, 0);
   endtask

   task automatic t_clear();
      step(1, 0, 0, 'h0D1);
      step(1, 0, 0, 'h0D2);
      step(1, 0, 0, 'h0D3);
      step(0, 1, 0, 0);
      step(0, 1, 0, 0);
      step(0, 1, 0, 0);
      step(0, 0, 1, 0);
      chk("R10", "peek on drained stack", int'(rdata_o), 0);
      chk("R10", "peek valid", int'(rvalid_o), 1);
      step(0, 0, 0, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_err++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_fill_drain();
      t_peek();
      t_underflow();
      t_swap();
      t_swap_empty();
      t_clear();
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end
endmodule